// File: doc/BRIEF.md
# Shadow Stack Push/Pop Unit

This unit keeps the shadow stack pointer of a hart and executes the shadow stack operations: pushing a return address, popping and checking a return address, reading and writing the pointer, and an atomic swap on shadow stack memory. It takes one operation at a time over a valid/ready handshake. When an operation needs memory it issues a single request, tagged as a shadow stack access, and holds it until the memory side returns a response.

Whether shadow stacks are active is worked out per operation from the current privilege, the virtualization bit and three environment-configuration enable bits. When they are inactive, push and pop-check complete as no-ops, the pointer read returns zero, and the pointer write and swap are refused as illegal. Faults leave the pointer untouched. Each fault is reported as a cause code plus a trap value.

Top module: `ssu_top`

## Requirements
- R1: After reset the pointer reads 0, `opReady` is 1, and `memReqValid`, `doneValid`, `rdValid` and `excValid` are 0.
- R2: Shadow stacks are active only if `privMode` is not 3 (machine), `mCfgSse` is 1, supervisor mode is present, and also `hCfgSse` is 1 when `virtMode` is 1, and also `sCfgSse` is 1 when `privMode` is 0 (user).
- R3: A push (`opCode` 1) issues a store (`memReqKind` 1) of `opData` at pointer − XLEN/8, with `memReqSize` = log2(XLEN/8) and `memReqShadow` set. The pointer takes that address only after a good response.
- R4: A pop-check (`opCode` 2) issues a load (`memReqKind` 0) at the pointer. On a returned value equal to `opData` the pointer rises by XLEN/8. Otherwise `excCause` is 3 with `excTval` 3 and the pointer is unchanged.
- R5: The pointer read (`opCode` 3) returns the pointer on `rdData` when active and 0 when inactive.
- R6: The pointer write (`opCode` 4) loads `opData` with its low log2(XLEN/8) bits forced to zero when active. When inactive it raises `excCause` 1 (illegal) with `excTval` 0 and leaves the pointer unchanged.
- R7: The swap issues one request of kind 2 at `opAddr` with `opData` as write data and returns the old memory value on `rdData`. The word form (`opCode` 5, size 2) sign-extends from bit 31. The full form (`opCode` 6, size log2(XLEN/8)) returns it unchanged.
- R8: A swap whose `opAddr` is not aligned to its access size raises `excCause` 2 (store access fault) with `excTval` = `opAddr` and issues no memory request.
- R9: A response with `memRespErr` set raises `excCause` 2 with `excTval` equal to the request address, gives no `rdValid`, and leaves the pointer unchanged. This applies to loads as well as to stores.
- R10: While a request is pending, `opReady` is 0 and the request address and data stay stable until `memRespValid`.
- R11: When inactive, push and pop-check issue no memory request and do not move the pointer. A swap raises `excCause` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation offered |
| opCode | input | 3 | 0 none, 1 push, 2 pop-check, 3 read pointer, 4 write pointer, 5 word swap, 6 full swap |
| opData | input | XLEN | Push value, compare value, new pointer, or swap store value |
| opAddr | input | XLEN | Swap address |
| privMode | input | 2 | 0 user, 1 supervisor, 3 machine |
| virtMode | input | 1 | Virtualized execution |
| mCfgSse | input | 1 | Machine-level shadow stack enable |
| hCfgSse | input | 1 | Hypervisor-level shadow stack enable |
| sCfgSse | input | 1 | Supervisor-level shadow stack enable |
| opReady | output | 1 | Unit idle, operation accepted when valid |
| memReqValid | output | 1 | Memory request pending |
| memReqKind | output | 2 | 0 load, 1 store, 2 swap |
| memReqAddr | output | XLEN | Request byte address |
| memReqWdata | output | XLEN | Store or swap data |
| memReqSize | output | 2 | log2 of access bytes |
| memReqShadow | output | 1 | Request is a shadow stack access |
| memRespValid | input | 1 | Response for the pending request |
| memRespData | input | XLEN | Loaded or old value, right-justified |
| memRespErr | input | 1 | Access fault on the request |
| doneValid | output | 1 | Operation completed this cycle |
| rdValid | output | 1 | `rdData` carries a result |
| rdData | output | XLEN | Result value |
| excValid | output | 1 | Operation raised an exception |
| excCause | output | 2 | 1 illegal, 2 store access fault, 3 software check |
| excTval | output | XLEN | Trap value |

## Verification
The pointer is internal, so a wrong pointer first shows up in the address of the next push or pop request, one cycle after that operation is accepted, or in the value a pointer read returns one cycle after acceptance. A wrong enable decision shows up one cycle after acceptance: a request appears where none should, or an illegal exception appears where a result was due. A bad compare or a bad fault path shows up on `excCause`/`excTval` in the cycle after the response. It can also show up later as a drifted pointer, which the following requests and reads expose.

// File: rtl/ssu_pkg.sv
package ssu_pkg;
  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_PUSH   = 3'd1,
    OP_POPCHK = 3'd2,
    OP_RDPTR  = 3'd3,
    OP_PTRWR  = 3'd4,
    OP_SWAPW  = 3'd5,
    OP_SWAPX  = 3'd6,
    OP_RSVD   = 3'd7
  } ssOp_e;

  typedef enum logic [1:0] {
    MEM_LOAD  = 2'd0,
    MEM_STORE = 2'd1,
    MEM_SWAP  = 2'd2,
    MEM_NONE  = 2'd3
  } memKind_e;

  typedef enum logic [1:0] {
    EXC_NONE    = 2'd0,
    EXC_ILLEGAL = 2'd1,
    EXC_STFAULT = 2'd2,
    EXC_SWCHECK = 2'd3
  } excCause_e;

  typedef enum logic [1:0] {RD_SSP, RD_ZERO, RD_MEMW, RD_MEMX} rdSrc_e;
  typedef enum logic [1:0] {TV_ZERO, TV_CODE, TV_OPADDR, TV_REQADDR} tvSrc_e;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_M = 2'd3;
  localparam int SWCHECK_CODE = 3;

  typedef struct packed {
    logic      capture;
    logic      sspFromReq;
    logic      sspPopInc;
    logic      sspFromOp;
    logic      done;
    logic      rdStb;
    rdSrc_e    rdSrc;
    logic      excStb;
    excCause_e cause;
    tvSrc_e    tvSrc;
  } strobe_t;
endpackage

// File: rtl/ssu_datapath.sv
module ssu_datapath
  import ssu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         stb,
  input  ssOp_e           opCode,
  input  logic [XLEN-1:0] opData,
  input  logic [XLEN-1:0] opAddr,
  input  logic [XLEN-1:0] memRespData,
  output logic [XLEN-1:0] sspQ,
  output logic [XLEN-1:0] reqAddr,
  output logic [XLEN-1:0] reqWdata,
  output memKind_e        reqKind,
  output logic [1:0]      reqSize,
  output logic            popMatch,
  output logic            swapMisaligned,
  output logic            doneValid,
  output logic            rdValid,
  output logic [XLEN-1:0] rdData,
  output logic            excValid,
  output excCause_e       excCause,
  output logic [XLEN-1:0] excTval
);
  localparam int BYTES = XLEN / 8;
  localparam int OFF   = $clog2(BYTES);
  localparam logic [XLEN-1:0] STEP = XLEN'(BYTES);

  logic [XLEN-1:OFF] sspHi;
  logic [XLEN-1:0]   nAddr;
  memKind_e          nKind;
  logic [1:0]        nSize;
  logic [XLEN-1:0]   memWordExt;
  logic [XLEN-1:0]   sspNext;

  assign sspQ = {sspHi, {OFF{1'b0}}};

  always_comb begin
    nAddr = opAddr;
    nKind = MEM_SWAP;
    nSize = 2'(OFF);
    case (opCode)
      OP_PUSH:   begin nAddr = sspQ - STEP; nKind = MEM_STORE; end
      OP_POPCHK: begin nAddr = sspQ;        nKind = MEM_LOAD;  end
      OP_SWAPW:  nSize = 2'd2;
      default:   ;
    endcase
  end

  assign swapMisaligned = (opCode == OP_SWAPW) ? (|opAddr[1:0]) : (|opAddr[OFF-1:0]);
  assign popMatch       = (memRespData == reqWdata);

  generate
    if (XLEN > 32) begin : g_sext
      assign memWordExt = {{(XLEN-32){memRespData[31]}}, memRespData[31:0]};
    end else begin : g_nosext
      assign memWordExt = memRespData;
    end
  endgenerate

  always_comb begin
    sspNext = sspQ;
    if (stb.sspFromReq)     sspNext = reqAddr;
    else if (stb.sspPopInc) sspNext = sspQ + STEP;
    else if (stb.sspFromOp) sspNext = opData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sspHi    <= '0;
      reqAddr  <= '0;
      reqWdata <= '0;
      reqKind  <= MEM_NONE;
      reqSize  <= '0;
    end else begin
      sspHi <= sspNext[XLEN-1:OFF];
      if (stb.capture) begin
        reqAddr  <= nAddr;
        reqWdata <= opData;
        reqKind  <= nKind;
        reqSize  <= nSize;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneValid <= 1'b0;
      rdValid   <= 1'b0;
      rdData    <= '0;
      excValid  <= 1'b0;
      excCause  <= EXC_NONE;
      excTval   <= '0;
    end else begin
      doneValid <= stb.done;
      rdValid   <= stb.rdStb;
      excValid  <= stb.excStb;
      excCause  <= stb.excStb ? stb.cause : EXC_NONE;
      case (stb.rdSrc)
        RD_SSP:  rdData <= sspQ;
        RD_MEMW: rdData <= memWordExt;
        RD_MEMX: rdData <= memRespData;
        default: rdData <= '0;
      endcase
      case (stb.tvSrc)
        TV_CODE:    excTval <= XLEN'(SWCHECK_CODE);
        TV_OPADDR:  excTval <= opAddr;
        TV_REQADDR: excTval <= reqAddr;
        default:    excTval <= '0;
      endcase
    end
  end

  // R9, R4: an exception never moves the pointer
  p_exc_keeps_ssp_r9: assert property (@(posedge clk) disable iff (!rstN)
    stb.excStb |=> $stable(sspQ));
  // R3: a completed push lowers the pointer by one slot
  p_push_moves_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.sspFromReq |=> sspQ == $past(sspQ) - STEP);
  // R4: a matched pop raises the pointer by one slot
  p_pop_moves_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.sspPopInc |=> sspQ == $past(sspQ) + STEP);
endmodule

// File: rtl/ssu_ctrl.sv
module ssu_ctrl
  import ssu_pkg::*;
#(
  parameter int XLEN         = 64,
  parameter bit SUPV_PRESENT = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  ssOp_e      opCode,
  input  logic [1:0] privMode,
  input  logic       virtMode,
  input  logic       mCfgSse,
  input  logic       hCfgSse,
  input  logic       sCfgSse,
  input  logic       swapMisaligned,
  input  logic       popMatch,
  input  logic       memRespValid,
  input  logic       memRespErr,
  output logic       opReady,
  output logic       memReqValid,
  output strobe_t    stb
);
  typedef enum logic {ST_IDLE, ST_WAIT} state_e;

  state_e state, nState;
  ssOp_e  pendOp;
  logic   ssEn;

  assign ssEn = SUPV_PRESENT && (privMode != PRIV_M) && mCfgSse &&
                (!virtMode || hCfgSse) && ((privMode != PRIV_U) || sCfgSse);

  assign opReady     = (state == ST_IDLE);
  assign memReqValid = (state == ST_WAIT);

  always_comb begin
    stb       = '0;
    stb.rdSrc = RD_SSP;
    stb.cause = EXC_NONE;
    stb.tvSrc = TV_ZERO;
    nState    = state;
    if (state == ST_IDLE && opValid) begin
      stb.done = 1'b1;
      case (opCode)
        OP_PUSH, OP_POPCHK: begin
          if (ssEn) begin
            stb.capture = 1'b1;
            stb.done    = 1'b0;
            nState      = ST_WAIT;
          end
        end
        OP_RDPTR: begin
          stb.rdStb = 1'b1;
          stb.rdSrc = ssEn ? RD_SSP : RD_ZERO;
        end
        OP_PTRWR: begin
          if (ssEn) stb.sspFromOp = 1'b1;
          else begin
            stb.excStb = 1'b1;
            stb.cause  = EXC_ILLEGAL;
          end
        end
        OP_SWAPW, OP_SWAPX: begin
          if (!ssEn || (opCode == OP_SWAPX && XLEN < 64)) begin
            stb.excStb = 1'b1;
            stb.cause  = EXC_ILLEGAL;
          end else if (swapMisaligned) begin
            stb.excStb = 1'b1;
            stb.cause  = EXC_STFAULT;
            stb.tvSrc  = TV_OPADDR;
          end else begin
            stb.capture = 1'b1;
            stb.done    = 1'b0;
            nState      = ST_WAIT;
          end
        end
        default: ;
      endcase
    end else if (state == ST_WAIT && memRespValid) begin
      nState   = ST_IDLE;
      stb.done = 1'b1;
      if (memRespErr) begin
        stb.excStb = 1'b1;
        stb.cause  = EXC_STFAULT;
        stb.tvSrc  = TV_REQADDR;
      end else begin
        case (pendOp)
          OP_PUSH: stb.sspFromReq = 1'b1;
          OP_POPCHK: begin
            if (popMatch) stb.sspPopInc = 1'b1;
            else begin
              stb.excStb = 1'b1;
              stb.cause  = EXC_SWCHECK;
              stb.tvSrc  = TV_CODE;
            end
          end
          OP_SWAPW: begin stb.rdStb = 1'b1; stb.rdSrc = RD_MEMW; end
          default:  begin stb.rdStb = 1'b1; stb.rdSrc = RD_MEMX; end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      pendOp <= OP_NOP;
    end else begin
      state <= nState;
      if (stb.capture) pendOp <= opCode;
    end
  end

  // R10: a pending request is held until its response arrives
  p_hold_until_resp_r10: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memRespValid |=> memReqValid);
  // R2: machine mode never reaches memory
  p_machine_no_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    opValid && opReady && privMode == PRIV_M |=> !memReqValid);
endmodule

// File: rtl/ssu_top.sv
module ssu_top
  import ssu_pkg::*;
#(
  parameter int XLEN         = 64,
  parameter bit SUPV_PRESENT = 1'b1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            opValid,
  input  logic [2:0]      opCode,
  input  logic [XLEN-1:0] opData,
  input  logic [XLEN-1:0] opAddr,
  input  logic [1:0]      privMode,
  input  logic            virtMode,
  input  logic            mCfgSse,
  input  logic            hCfgSse,
  input  logic            sCfgSse,
  output logic            opReady,
  output logic            memReqValid,
  output logic [1:0]      memReqKind,
  output logic [XLEN-1:0] memReqAddr,
  output logic [XLEN-1:0] memReqWdata,
  output logic [1:0]      memReqSize,
  output logic            memReqShadow,
  input  logic            memRespValid,
  input  logic [XLEN-1:0] memRespData,
  input  logic            memRespErr,
  output logic            doneValid,
  output logic            rdValid,
  output logic [XLEN-1:0] rdData,
  output logic            excValid,
  output logic [1:0]      excCause,
  output logic [XLEN-1:0] excTval
);
  strobe_t         stb;
  logic            popMatch;
  logic            swapMisaligned;
  logic [XLEN-1:0] sspQ;
  memKind_e        reqKind;
  excCause_e       causeQ;

  ssu_ctrl #(.XLEN(XLEN), .SUPV_PRESENT(SUPV_PRESENT)) ctrl_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(ssOp_e'(opCode)),
    .privMode(privMode), .virtMode(virtMode), .mCfgSse(mCfgSse),
    .hCfgSse(hCfgSse), .sCfgSse(sCfgSse), .swapMisaligned(swapMisaligned),
    .popMatch(popMatch), .memRespValid(memRespValid), .memRespErr(memRespErr),
    .opReady(opReady), .memReqValid(memReqValid), .stb(stb)
  );

  ssu_datapath #(.XLEN(XLEN)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .opCode(ssOp_e'(opCode)),
    .opData(opData), .opAddr(opAddr), .memRespData(memRespData),
    .sspQ(sspQ), .reqAddr(memReqAddr), .reqWdata(memReqWdata),
    .reqKind(reqKind), .reqSize(memReqSize), .popMatch(popMatch),
    .swapMisaligned(swapMisaligned), .doneValid(doneValid), .rdValid(rdValid),
    .rdData(rdData), .excValid(excValid), .excCause(causeQ), .excTval(excTval)
  );

  assign memReqKind   = reqKind;
  assign memReqShadow = memReqValid;
  assign excCause     = causeQ;

  // R10: address and data do not move while waiting
  p_req_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memRespValid |=> $stable(memReqAddr) && $stable(memReqWdata));
  // R8: every issued request is naturally aligned
  p_req_aligned_r8: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (memReqAddr & ((XLEN'(1) << memReqSize) - XLEN'(1))) == '0);
  // R9: a faulted completion carries no result
  p_exc_no_rd_r9: assert property (@(posedge clk) disable iff (!rstN)
    excValid |-> doneValid && !rdValid);
endmodule

// File: tb/ssu_top_tb.sv
module ssu_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 64;

  logic clk = 0;
  logic rstN = 0;
  logic opValid = 0;
  logic [2:0] opCode = 0;
  logic [63:0] opData = 0, opAddr = 0;
  logic [1:0] privMode = 1;
  logic virtMode = 0, mCfgSse = 1, hCfgSse = 0, sCfgSse = 0;
  logic opReady, memReqValid, memReqShadow;
  logic [1:0] memReqKind, memReqSize;
  logic [63:0] memReqAddr, memReqWdata;
  logic memRespValid = 0, memRespErr = 0;
  logic [63:0] memRespData = 0;
  logic doneValid, rdValid, excValid;
  logic [63:0] rdData, excTval;
  logic [1:0] excCause;

  int nTests = 0, nFail = 0;
  bit finished = 0;
  logic [63:0] mSsp = 0;
  logic [63:0] mem [logic [63:0]];

  always #(CLK_PERIOD/2) clk = ~clk;

  ssu_top #(.XLEN(XLEN)) dut_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .opData(opData),
    .opAddr(opAddr), .privMode(privMode), .virtMode(virtMode), .mCfgSse(mCfgSse),
    .hCfgSse(hCfgSse), .sCfgSse(sCfgSse), .opReady(opReady),
    .memReqValid(memReqValid), .memReqKind(memReqKind), .memReqAddr(memReqAddr),
    .memReqWdata(memReqWdata), .memReqSize(memReqSize), .memReqShadow(memReqShadow),
    .memRespValid(memRespValid), .memRespData(memRespData), .memRespErr(memRespErr),
    .doneValid(doneValid), .rdValid(rdValid), .rdData(rdData), .excValid(excValid),
    .excCause(excCause), .excTval(excTval)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit modelEn();
    return (privMode != 2'd3) && mCfgSse && (!virtMode || hCfgSse) &&
           (privMode != 2'd0 || sCfgSse);
  endfunction

  function automatic logic [63:0] memRead(input logic [63:0] a, input logic [1:0] sz);
    logic [63:0] v = mem.exists(a) ? mem[a] : 64'd0;
    return (sz == 2'd2) ? {32'd0, v[31:0]} : v;
  endfunction

  task automatic runOp(input logic [2:0] code, input logic [63:0] data,
                       input logic [63:0] addr, input bit injErr, input string req);
    bit en = modelEn();
    bit expReq = 0, expRdV = 0, expExc = 0, sawReq = 0;
    logic [1:0] expKind = 0, expSize = 3, expCause = 0;
    logic [63:0] expAddr = 0, expRd = 0, expTval = 0, nextSsp = mSsp, old;
    logic [63:0] a0, w0;
    case (code)
      3'd1: if (en) begin
        expReq = 1; expKind = 1; expAddr = mSsp - 8;
        if (injErr) begin expExc = 1; expCause = 2; expTval = expAddr; end
        else nextSsp = expAddr;
      end
      3'd2: if (en) begin
        expReq = 1; expKind = 0; expAddr = mSsp;
        if (injErr) begin expExc = 1; expCause = 2; expTval = expAddr; end
        else if (memRead(mSsp, 3) != data) begin expExc = 1; expCause = 3; expTval = 3; end
        else nextSsp = mSsp + 8;
      end
      3'd3: begin expRdV = 1; expRd = en ? mSsp : 64'd0; end
      3'd4: if (en) nextSsp = data & ~64'd7;
            else begin expExc = 1; expCause = 1; end
      3'd5, 3'd6: begin
        expSize = (code == 3'd5) ? 2'd2 : 2'd3;
        if (!en) begin expExc = 1; expCause = 1; end
        else if ((code == 3'd5 && addr[1:0] != 0) || (code == 3'd6 && addr[2:0] != 0)) begin
          expExc = 1; expCause = 2; expTval = addr;
        end else begin
          expReq = 1; expKind = 2; expAddr = addr;
          if (injErr) begin expExc = 1; expCause = 2; expTval = addr; end
          else begin
            old = memRead(addr, expSize);
            expRdV = 1;
            expRd = (code == 3'd5) ? {{32{old[31]}}, old[31:0]} : old;
          end
        end
      end
      default: ;
    endcase

    opCode = code; opData = data; opAddr = addr; opValid = 1;
    @(posedge clk); @(negedge clk);
    opValid = 0;
    if (memReqValid) begin
      sawReq = 1;
      chk(memReqKind == expKind, req, "req kind", 64'(memReqKind), 64'(expKind));
      chk(memReqAddr == expAddr, req, "req addr", memReqAddr, expAddr);
      chk(memReqSize == expSize, req, "req size", 64'(memReqSize), 64'(expSize));
      chk(memReqShadow == 1'b1, req, "req shadow tag", 64'(memReqShadow), 64'd1);
      if (expKind != 0)
        chk(memReqWdata == data, req, "req wdata", memReqWdata, data);
      a0 = memReqAddr; w0 = memReqWdata;
      @(posedge clk); @(negedge clk);
      chk(memReqValid && !opReady, "R10", "held pending", 64'(memReqValid), 64'd1);
      chk(memReqAddr == a0 && memReqWdata == w0, "R10", "req stable", memReqAddr, a0);
      chk(!doneValid, "R3", "no early done", 64'(doneValid), 64'd0);
      memRespData = memRead(memReqAddr, memReqSize);
      memRespErr = injErr;
      memRespValid = 1;
      if (!injErr && memReqKind != 2'd0)
        mem[memReqAddr] = (memReqSize == 2'd2) ? {32'd0, memReqWdata[31:0]} : memReqWdata;
      @(posedge clk); @(negedge clk);
      memRespValid = 0; memRespErr = 0;
    end
    chk(sawReq == expReq, req, "request issued", 64'(sawReq), 64'(expReq));
    chk(doneValid == 1'b1, req, "done", 64'(doneValid), 64'd1);
    chk(rdValid == expRdV, req, "rd valid", 64'(rdValid), 64'(expRdV));
    if (expRdV) chk(rdData == expRd, req, "rd data", rdData, expRd);
    chk(excValid == expExc, req, "exc valid", 64'(excValid), 64'(expExc));
    if (expExc) begin
      chk(excCause == expCause, req, "exc cause", 64'(excCause), 64'(expCause));
      chk(excTval == expTval, req, "exc tval", excTval, expTval);
    end
    mSsp = nextSsp;
    @(negedge clk);
    chk(!doneValid && opReady, req, "back to idle", 64'(doneValid), 64'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nFail++; nTests++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(opReady == 1, "R1", "ready after reset", 64'(opReady), 64'd1);
    chk(!memReqValid && !doneValid && !rdValid && !excValid, "R1", "idle outputs",
        64'(memReqValid), 64'd0);
    rstN = 1;
    @(negedge clk);
    runOp(3'd3, 0, 0, 0, "R1");
    runOp(3'd4, 64'h1007, 0, 0, "R6");
    runOp(3'd3, 0, 0, 0, "R5");
    runOp(3'd1, 64'hAAAA, 0, 0, "R3");
    runOp(3'd1, 64'hBBBB, 0, 0, "R3");
    runOp(3'd3, 0, 0, 0, "R5");
    runOp(3'd2, 64'hBBBB, 0, 0, "R4");
    runOp(3'd2, 64'h1234, 0, 0, "R4");
    runOp(3'd2, 64'hAAAA, 0, 0, "R4");
    runOp(3'd3, 0, 0, 0, "R5");
    runOp(3'd1, 64'hCCCC, 0, 1, "R9");
    runOp(3'd2, 64'h0, 0, 1, "R9");
    runOp(3'd3, 0, 0, 0, "R9");
    mem[64'h2004] = 64'h8000_0001;
    mem[64'h3000] = 64'h1122_3344_5566_7788;
    runOp(3'd5, 64'hDEAD_BEEF_0000_0042, 64'h2004, 0, "R7");
    runOp(3'd5, 64'h5, 64'h2004, 0, "R7");
    runOp(3'd6, 64'hFFFF_0000_FFFF_0000, 64'h3000, 0, "R7");
    runOp(3'd6, 64'h0, 64'h3000, 0, "R7");
    runOp(3'd6, 64'h0, 64'h3004, 0, "R8");
    runOp(3'd5, 64'h0, 64'h2006, 0, "R8");
    runOp(3'd6, 64'h9, 64'h3000, 1, "R9");
    privMode = 2'd3;
    runOp(3'd1, 64'h77, 0, 0, "R2");
    runOp(3'd3, 0, 0, 0, "R2");
    runOp(3'd4, 64'h5000, 0, 0, "R6");
    privMode = 2'd0; sCfgSse = 0;
    runOp(3'd2, 64'h77, 0, 0, "R11");
    runOp(3'd5, 64'h1, 64'h2004, 0, "R11");
    sCfgSse = 1;
    runOp(3'd3, 0, 0, 0, "R2");
    privMode = 2'd1; virtMode = 1; hCfgSse = 0;
    runOp(3'd1, 64'h99, 0, 0, "R11");
    runOp(3'd3, 0, 0, 0, "R2");
    hCfgSse = 1;
    runOp(3'd1, 64'h99, 0, 0, "R2");
    runOp(3'd2, 64'h99, 0, 0, "R2");
    virtMode = 0; mCfgSse = 0;
    runOp(3'd3, 0, 0, 0, "R2");
    runOp(3'd6, 64'h1, 64'h3000, 0, "R11");
    mCfgSse = 1;
    runOp(3'd3, 0, 0, 0, "R5");
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule